// File: doc/BRIEF.md
# I2C Register-Pair Expander Slave

This block is the serial front end of a 16-bit I/O expander. It watches the two I2C bus lines, which are sampled on the system clock. It answers its own 7-bit address and holds eight byte-wide registers arranged as four pairs: two input ports, two output ports, two polarity-inversion masks and two direction (configuration) masks. The stored registers drive the expander's output, polarity and configuration buses directly. The input-port values are taken from two pin buses at the moment they are read.

A master writes the address with the direction bit clear and then sends a command byte, whose low three bits set a register pointer. After that it either sends data bytes or issues a repeated start and reads. After every acknowledged byte the pointer swaps to the other register of the same pair, so a long transfer ping-pongs between the two halves of the pair. A repeated start does not reload the pointer from the original command. It keeps whichever register was being accessed when the restart arrived.

Top module: `i2c_pair_expander`

## Requirements
- R1: After reset both output registers and both configuration registers read 0xFF, both polarity registers read 0x00, and the SDA drive enable is low.
- R2: The slave acknowledges an address byte only when bits [7:1] equal 0100 followed by addr_strap_i[2:0] (MSB first, bit 0 = R/W with 0 = write). After an address that does not match, it never drives SDA until the next start condition.
- R3: The byte after a write address is the command. Its bits [2:0] select the register: 0/1 input port 0/1, 2/3 output 0/1, 4/5 polarity 0/1, 6/7 configuration 0/1. The slave acknowledges the command byte and every write data byte by driving SDA low during the ninth clock.
- R4: A write data byte is committed to the selected register once all eight bits have arrived. If a stop or start ends a byte early, that partial byte changes nothing.
- R5: After each acknowledged data byte, in either direction, the pointer toggles bit 0 and stays within its pair. A run of reads starting at index 1 returns 1, 0, 1, and so on.
- R6: Writes addressed to index 0 or 1 are acknowledged but change no register.
- R7: A read returns the selected register. Input port n returns in<n>_i XOR polarity register n. The byte is captured on the rising SCL edge of the acknowledge clock that comes before it, so pin changes after that edge show up only in a later byte.
- R8: When the master does not acknowledge a read byte, the slave ends the read and keeps SDA released.
- R9: On a repeated start the pointer keeps the register being accessed at that moment. A read that follows starts there and not at the original command index.
- R10: The SDA drive enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| addr_strap_i | input | 3 | Low three address bits from strap pins |
| in0_i | input | 8 | Input port 0 pin levels |
| in1_i | input | 8 | Input port 1 pin levels |
| sda_oe_o | output | 1 | Open-drain SDA pull-low enable |
| out0_o | output | 8 | Output register 0 |
| out1_o | output | 8 | Output register 1 |
| pol0_o | output | 8 | Polarity inversion register 0 |
| pol1_o | output | 8 | Polarity inversion register 1 |
| cfg0_o | output | 8 | Configuration register 0 |
| cfg1_o | output | 8 | Configuration register 1 |

## Verification
The assertions check, on every cycle, that the SDA drive moves only while SCL is low and stays off while the slave is idle, ignoring the bus, or waiting for the master's acknowledge. They also check that the drive is held during command and write acknowledges, that the pointer leaves its pair only when a command is loaded, and that registers change only on a write commit. The bench scenarios cover what needs whole transactions to show: address decoding against the straps, readback of every register, polarity applied to the input pins, the acknowledge-clock capture point, discarded partial bytes, and the pointer kept across a repeated start.

// File: rtl/exp_pkg.sv
package exp_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] IDX_OUT0 = 3'd2;
  localparam logic [IDX_W-1:0] IDX_POL0 = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CFG0 = 3'd6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } state_e;
endpackage

// File: rtl/exp_bus_cond.sv
module exp_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges while SCL stays high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/exp_regfile.sv
module exp_regfile
  import exp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [DW-1:0]    in0_i,
  input  logic [DW-1:0]    in1_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    out0_o,
  output logic [DW-1:0]    out1_o,
  output logic [DW-1:0]    pol0_o,
  output logic [DW-1:0]    pol1_o,
  output logic [DW-1:0]    cfg0_o,
  output logic [DW-1:0]    cfg1_o
);
  localparam int FIRST_RW = int'(IDX_OUT0);

  logic [DW-1:0] store_q [FIRST_RW:NUM_REGS-1];
  logic [DW-1:0] pins    [2];
  logic [DW-1:0] in_eff  [2];

  function automatic logic [DW-1:0] rst_val(input int idx);
    // polarity pair resets to zero, output and direction pairs to ones
    if (idx / 2 == int'(IDX_POL0) / 2) return '0;
    return '1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = FIRST_RW; i < NUM_REGS; i++) store_q[i] <= rst_val(i);
    end else if (wr_en_i && wr_idx_i >= IDX_OUT0) begin
      store_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign pins[0] = in0_i;
  assign pins[1] = in1_i;

  for (genvar p = 0; p < 2; p++) begin : g_in
    assign in_eff[p] = pins[p] ^ store_q[int'(IDX_POL0) + p];
  end

  always_comb begin
    if (rd_idx_i < IDX_OUT0) rd_data_o = in_eff[rd_idx_i[0]];
    else                     rd_data_o = store_q[rd_idx_i];
  end

  assign out0_o = store_q[int'(IDX_OUT0)];
  assign out1_o = store_q[int'(IDX_OUT0) + 1];
  assign pol0_o = store_q[int'(IDX_POL0)];
  assign pol1_o = store_q[int'(IDX_POL0) + 1];
  assign cfg0_o = store_q[int'(IDX_CFG0)];
  assign cfg1_o = store_q[int'(IDX_CFG0) + 1];
endmodule

// File: rtl/i2c_pair_expander.sv
module i2c_pair_expander
  import exp_pkg::*;
#(
  parameter int         DW          = 8,
  parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    addr_strap_i,
  input  logic [DW-1:0] in0_i,
  input  logic [DW-1:0] in1_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] out0_o,
  output logic [DW-1:0] out1_o,
  output logic [DW-1:0] pol0_o,
  output logic [DW-1:0] pol1_o,
  output logic [DW-1:0] cfg0_o,
  output logic [DW-1:0] cfg1_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  state_e           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    rx_q, tx_q;
  logic [IDX_W-1:0] ptr_q;
  logic             rw_q, oe_q, done_q, acked_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, cmd_load, addr_hit, byte_end;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    rd_data;

  exp_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign byte_end = scl_fall && done_q;
  assign addr_hit = rx_q[DW-1:1] == {ADDR_PREFIX, addr_strap_i};
  assign wr_en    = (state_q == ST_WR)  && byte_end;
  assign cmd_load = (state_q == ST_CMD) && byte_end;
  // during the master acknowledge, prefetch the partner register
  assign rd_idx   = (state_q == ST_RD_ACK) ? {ptr_q[IDX_W-1:1], ~ptr_q[0]} : ptr_q;

  exp_regfile #(.DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (ptr_q),
    .wr_data_i (rx_q),
    .rd_idx_i  (rd_idx),
    .in0_i     (in0_i),
    .in1_i     (in1_i),
    .rd_data_o (rd_data),
    .out0_o    (out0_o),
    .out1_o    (out1_o),
    .pol0_o    (pol0_o),
    .pol1_o    (pol1_o),
    .cfg0_o    (cfg0_o),
    .cfg1_o    (cfg1_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      acked_q <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WR: begin
          if (scl_rise) begin
            rx_q   <= {rx_q[DW-2:0], sda_i};
            cnt_q  <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
            done_q <= (cnt_q == LAST_BIT);
          end
          if (byte_end) begin
            done_q <= 1'b0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_q <= ST_ADDR_ACK;
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_CMD) begin
              ptr_q   <= rx_q[IDX_W-1:0];
              state_q <= ST_CMD_ACK;
              oe_q    <= 1'b1;
            end else begin
              state_q <= ST_WR_ACK;
              oe_q    <= 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_rise && rw_q) tx_q <= rd_data;
          if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD;
              oe_q    <= ~tx_q[DW-1];
            end else begin
              state_q <= ST_CMD;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_CMD_ACK: begin
          if (scl_fall) begin
            state_q <= ST_WR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_q  <= ST_WR;
            cnt_q    <= '0;
            oe_q     <= 1'b0;
            ptr_q[0] <= ~ptr_q[0];
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_q <= ST_RD_ACK;
              cnt_q   <= '0;
              oe_q    <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              tx_q  <= {tx_q[DW-2:0], 1'b0};
              oe_q  <= ~tx_q[DW-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            acked_q <= ~sda_i;
            if (!sda_i) begin
              ptr_q <= rd_idx;
              tx_q  <= rd_data;
            end
          end
          if (scl_fall) begin
            if (acked_q) begin
              state_q <= ST_RD;
              oe_q    <= ~tx_q[DW-1];
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/exp_checker.sv
module exp_checker
  import exp_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_i,
  input state_e           state_i,
  input logic [IDX_W-1:0] ptr_i,
  input logic             cmd_load_i,
  input logic             wr_en_i,
  input logic [6*DW-1:0]  regs_i
);
  a_r10_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !$past(scl_i));

  a_r2_quiet_when_unaddressed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE || state_i == ST_SKIP) |-> !sda_oe_i);

  a_r8_release_master_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD_ACK) |-> !sda_oe_i);

  a_r3_ack_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CMD_ACK || state_i == ST_WR_ACK) |-> sda_oe_i);

  a_r5_ptr_stays_in_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ptr_i != $past(ptr_i)) && !$past(cmd_load_i)) |-> ptr_i[IDX_W-1:1] == $past(ptr_i[IDX_W-1:1]));

  a_r4_regs_change_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> regs_i == $past(regs_i));
endmodule

bind i2c_pair_expander exp_checker #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_i   (sda_oe_o),
  .state_i    (state_q),
  .ptr_i      (ptr_q),
  .cmd_load_i (cmd_load),
  .wr_en_i    (wr_en),
  .regs_i     ({out0_o, out1_o, pol0_o, pol1_o, cfg0_o, cfg1_o})
);

// File: tb/sim_i2c_pair_expander.sv
module sim_i2c_pair_expander;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 4;
  localparam int WD_CYCLES  = 150000;
  localparam logic [2:0] STRAP  = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b0100, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b0100, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] in0 = 8'h00, in1 = 8'h00;
  logic sda_oe;
  logic [7:0] out0, out1, pol0, pol1, cfg0, cfg1;
  wire bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_pair_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(bus),
    .addr_strap_i(STRAP), .in0_i(in0), .in1_i(in1),
    .sda_oe_o(sda_oe), .out0_o(out0), .out1_o(out1),
    .pol0_o(pol0), .pol1_o(pol1), .cfg0_o(cfg0), .cfg1_o(cfg1)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_val(input int idx);
    if (idx == 0) return in0 ^ mdl[4];
    if (idx == 1) return in1 ^ mdl[5];
    return mdl[idx];
  endfunction

  task automatic chk_ports(input string tag);
    chk(tag, out0, mdl[2]); chk(tag, out1, mdl[3]);
    chk(tag, pol0, mdl[4]); chk(tag, pol1, mdl[5]);
    chk(tag, cfg0, mdl[6]); chk(tag, cfg1, mdl[7]);
  endtask

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wc(H); scl = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl = 1'b0; wc(H);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wc(H); scl = 1'b1; wc(H); sda_m = 1'b1; wc(H);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wc(H); scl = 1'b1; wc(H); scl = 1'b0; wc(H);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wc(H); scl = 1'b1; wc(H / 2); b = bus; wc(H - H / 2); scl = 1'b0; wc(H);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~m_ack);
  endtask

  task automatic write_regs(input int idx, input int n, input logic [7:0] d0,
                            input logic [7:0] d1, input string tag);
    logic a;
    i2c_start();
    wr_byte(ADDR_W, a); chk(tag, 8'(a), 8'd1);
    wr_byte(8'(idx), a); chk(tag, 8'(a), 8'd1);
    for (int i = 0; i < n; i++) begin
      int k;
      k = idx ^ (i & 1);
      wr_byte(i == 0 ? d0 : d1, a); chk(tag, 8'(a), 8'd1);
      if (k >= 2) mdl[k] = (i == 0) ? d0 : d1;
    end
    i2c_stop();
  endtask

  task automatic read_regs(input int idx, input int n, input string tag);
    logic a;
    logic [7:0] d;
    i2c_start();
    wr_byte(ADDR_W, a);
    wr_byte(8'(idx), a);
    i2c_start();
    wr_byte(ADDR_R, a); chk(tag, 8'(a), 8'd1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      chk(tag, d, exp_val(idx ^ (i & 1)));
    end
    wc(2);
    chk({tag, " R8 release after nack"}, 8'(sda_oe), 8'd0);
    i2c_stop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 8; i++) mdl[i] = (i == 4 || i == 5) ? 8'h00 : 8'hFF;
    wc(5);
    rst_n = 1'b1;
    wc(3);

    // R1 reset state
    chk_ports("R1 reset");
    chk("R1 oe", 8'(sda_oe), 8'd0);

    // R3 R4 R5 writes across pairs
    write_regs(2, 2, 8'h5A, 8'hC3, "R3 ack");
    chk_ports("R4 R5 out pair");
    write_regs(7, 2, 8'h0F, 8'hF0, "R3 ack");
    chk_ports("R5 cfg pair from odd");
    write_regs(4, 1, 8'h33, 8'h00, "R3 ack");
    chk_ports("R4 single byte");

    // R3 R7 sweep every writable register and read back
    for (int idx = 2; idx < 8; idx++) begin
      write_regs(idx, 1, 8'(idx * 37 + 5), 8'h00, "R3 sweep ack");
      read_regs(idx, 1, "R7 sweep readback");
    end
    chk_ports("R4 sweep ports");

    // R4 partial byte dropped on stop
    i2c_start();
    wr_byte(ADDR_W, a); wr_byte(8'd3, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    i2c_stop();
    chk_ports("R4 partial byte");

    // R6 input port writes acked but ignored
    write_regs(0, 2, 8'h12, 8'h34, "R6 ack");
    chk_ports("R6 no side effect");

    // R7 R5 input read with polarity over several patterns
    for (int k = 0; k < 6; k++) begin
      in0 = 8'(k * 29 + 3);
      in1 = 8'(~(k * 53 + 7));
      read_regs(k & 1, 3, "R5 R7 input alternate");
    end

    // R7 capture at the ack clock before each byte
    in1 = 8'hA5;
    i2c_start();
    wr_byte(ADDR_W, a); wr_byte(8'd1, a);
    i2c_start();
    wr_byte(ADDR_R, a);
    in1 = 8'h3C;
    rd_byte(1'b1, d); chk("R7 old sample", d, 8'hA5 ^ mdl[5]);
    rd_byte(1'b1, d); chk("R7 partner", d, exp_val(0));
    rd_byte(1'b0, d); chk("R7 new sample", d, 8'h3C ^ mdl[5]);
    wc(2);
    chk("R8 nack release", 8'(sda_oe), 8'd0);
    i2c_stop();

    // R9 restart keeps pointer of the register in progress
    in0 = 8'h95 ^ mdl[4];
    in1 = 8'h4E;
    i2c_start();
    wr_byte(ADDR_W, a); wr_byte(8'd1, a);
    i2c_start();
    wr_byte(ADDR_R, a);
    rd_byte(1'b1, d); chk("R9 first port1", d, exp_val(1));
    i2c_start();
    wr_byte(ADDR_R, a); chk("R9 readdress ack", 8'(a), 8'd1);
    rd_byte(1'b0, d); chk("R9 resumes port0", d, 8'h95);
    i2c_stop();
    i2c_start();
    wr_byte(ADDR_R, a);
    rd_byte(1'b0, d); chk("R9 pointer kept", d, 8'h95);
    i2c_stop();

    // R2 address mismatch: strap bit and prefix
    i2c_start();
    wr_byte({4'b0100, STRAP ^ 3'b001, 1'b0}, a); chk("R2 strap mismatch", 8'(a), 8'd0);
    wr_byte(8'd2, a); chk("R2 silent cmd", 8'(a), 8'd0);
    wr_byte(8'h00, a); chk("R2 silent data", 8'(a), 8'd0);
    i2c_stop();
    i2c_start();
    wr_byte({4'b0110, STRAP, 1'b0}, a); chk("R2 prefix mismatch", 8'(a), 8'd0);
    wr_byte(8'd6, a); chk("R2 silent cmd", 8'(a), 8'd0);
    i2c_stop();
    chk_ports("R2 no write");
    write_regs(3, 1, 8'h81, 8'h00, "R2 match after mismatch");
    chk_ports("R2 match write");

    wc(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule